// File: doc/BRIEF.md
# Four-Port PS/2 Host Shift Engine

This block lets a host serve four PS/2 ports with a single shared bit engine. Each port has an open-drain clock line and an open-drain data line. The block reads each line through a synchroniser and a debounce filter whose length software selects. It drives a line only by pulling it low. Software enables a port by releasing its clock through a per-port clock-override bit. Holding every port clock low keeps the engine in reset and clears the transaction status. The first enabled port whose clock falls becomes the active port. Its number is reported with a fixed non-contiguous code.

In receive mode the engine collects an 11-bit frame, checks odd parity and the start and stop bits, and leaves the byte in the data register. In transmit mode software holds the clock low, loads the byte and pulls the port's data line low (request-to-send), then releases the clock. The device then generates the clock. The engine places the data bits LSB first, then the parity bit, releases the line for the stop bit and samples the device's acknowledge. A start flag and an end flag, each with its own enable, form the interrupt.

Top module: `ps2Host`

Register map (3-bit address, 8-bit data):
- 0 DATA: transmit byte on write; received byte or last written byte on read.
- 1 STAT (read only): [0] start flag, [1] end flag, [2] parity error, [3] frame error, [6:4] active-port code.
- 2 CTRL: [0] engine enable, [1] transmit mode, [2] weak pull-up enable, [6:4] debounce select.
- 3 OSIG: port clock overrides at bits 3, 4, 5, 7 (ports 0..3), port data overrides at bits 0, 1, 2, 6 (ports 0..3). An override bit of 1 releases the line and 0 pulls it low.
- 4 IEN: [0] start interrupt enable, [1] end interrupt enable, [4] wake enable (stored only), [7] clock select (stored only).

## Requirements
- R1: After reset, STAT reads 0x00, CTRL reads 0x00, OSIG reads 0x47, irq is 0, every clock line is pulled low (ps2ClkOe = 4'hF) and no data line is pulled (ps2DatOe = 4'h0).
- R2: ps2ClkOe bit i is 1 exactly when the clock override of port i is 0. While CTRL[0] is 0, or while all four clock overrides are 0, the engine stays in reset and STAT[1:0] reads 0.
- R3: In receive mode a frame is made of 11 falling clock edges: start, 8 data bits LSB first, parity, stop. After the 11th edge STAT[1] is 1 and DATA holds the byte.
- R4: STAT[0] sets on the start-bit edge and stays set until the engine is reset. STAT[6:4] gives the active port as 1, 2, 4, 5 for ports 0, 1, 2, 3, and reads 0 when no frame has started.
- R5: In receive mode STAT[2] sets at frame end when the 8 data bits and the parity bit hold an even number of ones (odd parity expected).
- R6: In receive mode STAT[3] sets when the start bit reads 1 or the stop bit reads 0.
- R7: A port whose clock override is 0 never becomes active. When several enabled ports show a falling clock in the same cycle, the lowest-numbered one wins.
- R8: In transmit mode, after the first device clock fall, the engine drives data bits 0..7, then odd parity, then releases the line. It samples the acknowledge at the 11th fall and sets STAT[1]. STAT[3] sets if the acknowledge is 1.
- R9: irq is 1 when the start flag and its enable are both 1, or when the end flag and its enable are both 1; otherwise irq is 0.
- R10: An input change shorter than the selected debounce length (2^CTRL[6:4] cycles, codes 0..5) is not seen by the engine.
- R11: A data override of 0 pulls that port's data line low (ps2DatOe bit = 1), except while the transmit engine owns the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| ps2ClkIn | input | 4 | Sensed clock line per port |
| ps2DatIn | input | 4 | Sensed data line per port |
| ps2ClkOe | output | 4 | Pull clock line low per port |
| ps2DatOe | output | 4 | Pull data line low per port |
| pullUpEn | output | 1 | Weak pull-up enable for the pads |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and a 5-bit debounce counter. This brings every debounce code from 1 to 32 cycles within reach, so a 10-cycle glitch can be shown both rejected and accepted. With the default four ports, every active-port code, the simultaneous-start priority and the masking of disabled ports can all be exercised. The frames run slowly enough against the filter latency that each data bit is settled before its clock fall.

// File: rtl/ps2hPkg.sv
package ps2hPkg;
  localparam int CH_NUM    = 4;
  localparam int BYTE_W    = 8;
  localparam int FRAME_LEN = 11;
  localparam int POS_W     = $clog2(FRAME_LEN + 1);
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_OSIG = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd4;

  localparam logic [BYTE_W-1:0] OSIG_RST  = 8'h47;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h77;
  localparam logic [BYTE_W-1:0] IEN_MASK  = 8'h93;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;
    logic       shift;
    logic       finish;
    logic [1:0] ch;
  } engStrb_t;

  function automatic logic [2:0] chCode(input logic [1:0] ch);
    case (ch)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic [CH_NUM-1:0] clkBits(input logic [BYTE_W-1:0] o);
    return {o[7], o[5], o[4], o[3]};
  endfunction

  function automatic logic [CH_NUM-1:0] datBits(input logic [BYTE_W-1:0] o);
    return {o[6], o[2], o[1], o[0]};
  endfunction
endpackage

// File: rtl/ps2hFilter.sv
module ps2hFilter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] sel,
  input  logic       lineIn,
  output logic       lineOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       stableCnt;
  logic [CNT_W-1:0]       lenM1;
  logic                   syncd;

  always_comb begin
    lenM1 = '1;
    if (int'(sel) < CNT_W) lenM1 = CNT_W'((32'd1 << sel) - 32'd1);
  end

  assign syncd = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOut   <= 1'b1;
      stableCnt <= '0;
    end else if (syncd == lineOut) begin
      stableCnt <= '0;
    end else if (stableCnt >= lenM1) begin
      lineOut   <= syncd;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end
endmodule

// File: rtl/ps2hCtrl.sv
module ps2hCtrl
  import ps2hPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              engRst,
  input  logic [CH_NUM-1:0] fClk,
  input  logic [CH_NUM-1:0] chEn,
  output engStrb_t          strb,
  output logic              busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} engSt_t;

  engSt_t            state;
  logic [POS_W-1:0]  pos;
  logic [1:0]        actCh;
  logic [CH_NUM-1:0] fClkQ;
  logic [CH_NUM-1:0] fallVec;
  logic [CH_NUM-1:0] startVec;
  logic [1:0]        pickCh;
  logic              pickHit;
  logic              actFall;

  assign fallVec  = fClkQ & ~fClk;
  assign startVec = fallVec & chEn;
  assign pickHit  = |startVec;
  assign actFall  = fallVec[actCh];

  always_comb begin
    pickCh = '0;
    for (int i = CH_NUM - 1; i >= 0; i--)
      if (startVec[i]) pickCh = 2'(i);
  end

  always_comb begin
    strb.ch     = (state == ST_IDLE) ? pickCh : actCh;
    strb.start  = !engRst && state == ST_IDLE && pickHit;
    strb.shift  = !engRst && state == ST_SHIFT && actFall && pos < POS_W'(FRAME_LEN - 1);
    strb.finish = !engRst && state == ST_SHIFT && actFall && pos == POS_W'(FRAME_LEN - 1);
  end

  assign busy = state != ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) fClkQ <= '1;
    else       fClkQ <= fClk;
  end

  always_ff @(posedge clk) begin
    if (!rstN || engRst) begin
      state <= ST_IDLE;
      pos   <= '0;
      actCh <= '0;
    end else if (strb.start) begin
      state <= ST_SHIFT;
      pos   <= POS_W'(1);
      actCh <= pickCh;
    end else if (strb.shift) begin
      pos <= pos + 1'b1;
    end else if (strb.finish) begin
      state <= ST_DONE;
    end
  end
endmodule

// File: rtl/ps2hDatapath.sv
module ps2hDatapath
  import ps2hPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  engStrb_t          strb,
  input  logic              busy,
  input  logic              sampDat,
  output logic              engRst,
  output logic [CH_NUM-1:0] chEn,
  output logic [2:0]        dbSel,
  output logic [CH_NUM-1:0] clkOe,
  output logic [CH_NUM-1:0] datOe,
  output logic              pullUpEn,
  output logic              irq,
  output logic [BYTE_W-1:0] statOut,
  output logic [BYTE_W-1:0] osigOut,
  output logic [BYTE_W-1:0] ctrlOut,
  output logic [BYTE_W-1:0] ienOut
);
  logic [BYTE_W-1:0] dataReg, ctrlReg, osigReg, ienReg;
  logic [BYTE_W:0]   shifter;
  logic              sot, eot, perr, ferr, txOut, xmt, txOwn;
  logic [2:0]        achCode;
  logic [CH_NUM-1:0] datOvr;

  assign xmt      = ctrlReg[1];
  assign engRst   = ~ctrlReg[0] | ~|clkBits(osigReg);
  assign chEn     = clkBits(osigReg);
  assign datOvr   = datBits(osigReg);
  assign dbSel    = ctrlReg[6:4];
  assign pullUpEn = ctrlReg[2];
  assign clkOe    = ~chEn;
  assign txOwn    = xmt & busy & ~engRst;
  assign irq      = (sot & ienReg[0]) | (eot & ienReg[1]);
  assign statOut  = {1'b0, achCode, ferr, perr, eot, sot};
  assign osigOut  = osigReg;
  assign ctrlOut  = ctrlReg;
  assign ienOut   = ienReg;

  for (genvar i = 0; i < CH_NUM; i++) begin : g_datOe
    assign datOe[i] = (txOwn && strb.ch == 2'(i)) ? ~txOut : ~datOvr[i];
  end

  always_comb begin
    case (regAddr)
      ADDR_DATA: regRdata = dataReg;
      ADDR_STAT: regRdata = statOut;
      ADDR_CTRL: regRdata = ctrlReg;
      ADDR_OSIG: regRdata = osigReg;
      ADDR_IEN:  regRdata = ienReg;
      default:   regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
      osigReg <= OSIG_RST;
      ienReg  <= '0;
      shifter <= '0;
      txOut   <= 1'b1;
      sot     <= 1'b0;
      eot     <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      achCode <= '0;
    end else begin
      if (regWr) begin
        case (regAddr)
          ADDR_DATA: dataReg <= regWdata;
          ADDR_CTRL: ctrlReg <= regWdata & CTRL_MASK;
          ADDR_OSIG: osigReg <= regWdata;
          ADDR_IEN:  ienReg  <= regWdata & IEN_MASK;
          default: ;
        endcase
      end
      if (engRst) begin
        sot     <= 1'b0;
        eot     <= 1'b0;
        perr    <= 1'b0;
        ferr    <= 1'b0;
        achCode <= '0;
        txOut   <= 1'b1;
      end else if (strb.start) begin
        sot     <= 1'b1;
        achCode <= chCode(strb.ch);
        if (xmt) begin
          txOut   <= dataReg[0];
          shifter <= {1'b1, ~^dataReg, dataReg[BYTE_W-1:1]};
        end else if (sampDat) begin
          ferr <= 1'b1;
        end
      end else if (strb.shift) begin
        if (xmt) begin
          txOut   <= shifter[0];
          shifter <= {1'b1, shifter[BYTE_W:1]};
        end else begin
          shifter <= {sampDat, shifter[BYTE_W:1]};
        end
      end else if (strb.finish) begin
        eot <= 1'b1;
        if (xmt) begin
          if (sampDat) ferr <= 1'b1;
        end else begin
          dataReg <= shifter[BYTE_W-1:0];
          if (~^shifter) perr <= 1'b1;
          if (!sampDat)  ferr <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2Host.sv
module ps2Host
  import ps2hPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_CNT_W   = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic [3:0]  ps2ClkIn,
  input  logic [3:0]  ps2DatIn,
  output logic [3:0]  ps2ClkOe,
  output logic [3:0]  ps2DatOe,
  output logic        pullUpEn,
  output logic        irq
);
  engStrb_t          strb;
  logic              busy, engRst;
  logic [CH_NUM-1:0] fClk, fDat, chEn;
  logic [2:0]        dbSel;
  logic [BYTE_W-1:0] statVec, osigVec, ctrlVec, ienVec;

  for (genvar i = 0; i < CH_NUM; i++) begin : g_flt
    ps2hFilter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(FLT_CNT_W)) u_fltClk (
      .clk(clk), .rstN(rstN), .sel(dbSel), .lineIn(ps2ClkIn[i]), .lineOut(fClk[i]));
    ps2hFilter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(FLT_CNT_W)) u_fltDat (
      .clk(clk), .rstN(rstN), .sel(dbSel), .lineIn(ps2DatIn[i]), .lineOut(fDat[i]));
  end

  ps2hCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .engRst(engRst), .fClk(fClk), .chEn(chEn),
    .strb(strb), .busy(busy));

  ps2hDatapath u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .strb(strb), .busy(busy), .sampDat(fDat[strb.ch]),
    .engRst(engRst), .chEn(chEn), .dbSel(dbSel), .clkOe(ps2ClkOe), .datOe(ps2DatOe),
    .pullUpEn(pullUpEn), .irq(irq), .statOut(statVec), .osigOut(osigVec),
    .ctrlOut(ctrlVec), .ienOut(ienVec));
endmodule

// File: rtl/ps2HostChk.sv
module ps2HostChk (
  input logic       clk,
  input logic       rstN,
  input logic       irq,
  input logic [7:0] statV,
  input logic [7:0] osigV,
  input logic [7:0] ctrlV,
  input logic [7:0] ienV
);
  logic engRstC;
  assign engRstC = !ctrlV[0] || ({osigV[7], osigV[5], osigV[4], osigV[3]} == 4'b0000);

  AST_RST_CLEARS_XFER: assert property (@(posedge clk) disable iff (!rstN)
    engRstC |=> statV[1:0] == 2'b00); // R2

  AST_SOT_STICKY: assert property (@(posedge clk) disable iff (!rstN || engRstC)
    statV[0] |=> statV[0]); // R4

  AST_ACH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    statV[6:4] != 3'd3 && statV[6:4] != 3'd6 && statV[6:4] != 3'd7); // R4

  AST_ACH_HELD: assert property (@(posedge clk) disable iff (!rstN || engRstC)
    statV[1] |=> $stable(statV[6:4])); // R4

  AST_EOT_AFTER_SOT: assert property (@(posedge clk) disable iff (!rstN)
    statV[1] |-> statV[0]); // R3

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statV[1:0] != 2'b00); // R9

  AST_IRQ_ON_EOT: assert property (@(posedge clk) disable iff (!rstN)
    (statV[1] && ienV[1]) |-> irq); // R9
endmodule

bind ps2Host ps2HostChk u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .statV(statVec), .osigV(osigVec),
  .ctrlV(ctrlVec), .ienV(ienVec));

// File: tb/ps2Host_bench.sv
module ps2Host_bench;
  localparam int HALF  = 40;
  localparam int VEC_N = 7;
  // {ch[1:0], byte[7:0], parityGood, stopBit, startBit}
  localparam logic [12:0] VEC [VEC_N] = '{
    {2'd0, 8'hA5, 1'b1, 1'b1, 1'b0},
    {2'd1, 8'h3C, 1'b1, 1'b1, 1'b0},
    {2'd2, 8'h01, 1'b1, 1'b1, 1'b0},
    {2'd3, 8'hFE, 1'b1, 1'b1, 1'b0},
    {2'd0, 8'h5A, 1'b0, 1'b1, 1'b0},
    {2'd3, 8'h81, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h00, 1'b1, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [3:0] devClk = '1, devDat = '1;
  logic [3:0] ps2ClkIn, ps2DatIn, ps2ClkOe, ps2DatOe;
  logic       pullUpEn, irq;
  int         nChk = 0, nErr = 0;
  logic       done = 1'b0;

  assign ps2ClkIn = devClk & ~ps2ClkOe;
  assign ps2DatIn = devDat & ~ps2DatOe;

  always #4 clk = ~clk;

  ps2Host u_ps2Host (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .ps2ClkIn(ps2ClkIn), .ps2DatIn(ps2DatIn), .ps2ClkOe(ps2ClkOe),
    .ps2DatOe(ps2DatOe), .pullUpEn(pullUpEn), .irq(irq));

  function automatic int clkPos(input int ch);
    return (ch == 3) ? 7 : ch + 3;
  endfunction
  function automatic int datPos(input int ch);
    return (ch == 3) ? 6 : ch;
  endfunction
  function automatic logic [2:0] expCode(input int ch);
    return (ch == 0) ? 3'd1 : (ch == 1) ? 3'd2 : (ch == 2) ? 3'd4 : 3'd5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input int ch, input logic [10:0] fr);
    for (int k = 0; k < 11; k++) begin
      devDat[ch] = fr[k];
      waitCyc(HALF);
      devClk[ch] = 1'b0;
      waitCyc(HALF);
      devClk[ch] = 1'b1;
    end
    waitCyc(HALF);
    devDat[ch] = 1'b1;
    waitCyc(10);
  endtask

  task automatic glitch(input int ch);
    devClk[ch] = 1'b0;
    waitCyc(10);
    devClk[ch] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    logic [7:0] r;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    rd(3'd1, r); chk("R1 stat", r, 8'h00);
    rd(3'd2, r); chk("R1 ctrl", r, 8'h00);
    rd(3'd3, r); chk("R1 osig", r, 8'h47);
    chk("R1 irq", irq, 1'b0);
    chk("R1 clkOe", ps2ClkOe, 4'hF);
    chk("R1 datOe", ps2DatOe, 4'h0);

    // table of receive frames: R3 R4 R5 R6
    for (int v = 0; v < VEC_N; v++) begin
      int ch;
      logic [7:0] b;
      logic pOk, stopB, startB, par;
      ch = int'(VEC[v][12:11]); b = VEC[v][10:3];
      pOk = VEC[v][2]; stopB = VEC[v][1]; startB = VEC[v][0];
      par = pOk ? ~^b : ^b;
      wr(3'd3, 8'h47);
      wr(3'd2, 8'h01);
      wr(3'd3, 8'h47 | 8'(1 << clkPos(ch)));
      waitCyc(20);
      sendFrame(ch, {stopB, par, b, startB});
      rd(3'd0, r); chk("R3 data byte", r, b);
      rd(3'd1, r);
      chk("R3 R4 R5 R6 stat", r,
          {1'b0, expCode(ch), (!stopB || startB), !pOk, 1'b1, 1'b1});
    end

    // R9 interrupt from end flag
    wr(3'd4, 8'h02); chk("R9 irq eot", irq, 1'b1);
    wr(3'd4, 8'h00); chk("R9 irq masked", irq, 1'b0);
    // R2 engine reset clears flags, clock holds follow overrides
    wr(3'd3, 8'h47);
    rd(3'd1, r); chk("R2 all clocks low clears", r[1:0], 2'b00);
    chk("R2 clkOe all held", ps2ClkOe, 4'hF);

    // R2 disable via enable bit
    wr(3'd2, 8'h01); wr(3'd3, 8'h4F); waitCyc(20);
    sendFrame(0, {1'b1, ~^8'h11, 8'h11, 1'b0});
    wr(3'd2, 8'h00);
    rd(3'd1, r); chk("R2 enable low clears", r[1:0], 2'b00);

    // R7 disabling ports produces no start
    wr(3'd2, 8'h01); wr(3'd3, 8'hFF); waitCyc(20);
    wr(3'd3, 8'h4F); waitCyc(30);
    rd(3'd1, r); chk("R7 masked ports ignored", r, 8'h00);
    // R7 simultaneous start on ports 0 and 2
    wr(3'd3, 8'h6F); waitCyc(20);
    chk("R2 clkOe pattern", ps2ClkOe, 4'b1010);
    devClk[0] = 1'b0; devClk[2] = 1'b0;
    waitCyc(HALF);
    rd(3'd1, r); chk("R7 lowest wins", r[6:4], 3'd1);
    chk("R4 sot set", r[0], 1'b1);
    // R9 start interrupt
    wr(3'd4, 8'h01); chk("R9 irq sot", irq, 1'b1);
    wr(3'd4, 8'h00); chk("R9 irq off", irq, 1'b0);
    devClk[0] = 1'b1; devClk[2] = 1'b1;

    // R10 debounce
    wr(3'd3, 8'h47); wr(3'd2, 8'h51); wr(3'd3, 8'h4F); waitCyc(40);
    glitch(0); waitCyc(80);
    rd(3'd1, r); chk("R10 glitch rejected at 32", r[0], 1'b0);
    wr(3'd2, 8'h01); waitCyc(10);
    glitch(0); waitCyc(20);
    rd(3'd1, r); chk("R10 glitch seen at 1", r[0], 1'b1);

    // R11 data override
    wr(3'd2, 8'h00); wr(3'd3, 8'h43); waitCyc(2);
    chk("R11 datOe", ps2DatOe, 4'b0100);

    // R8 transmit
    for (int t = 0; t < 2; t++) begin
      int ch;
      logic [7:0] b;
      logic ack;
      logic [10:0] got;
      ch = (t == 0) ? 1 : 3; b = (t == 0) ? 8'hC5 : 8'h00; ack = (t == 0);
      wr(3'd3, 8'h47); wr(3'd2, 8'h03); wr(3'd0, b); waitCyc(20);
      wr(3'd3, (8'h47 & ~8'(1 << datPos(ch))) | 8'(1 << clkPos(ch)));
      waitCyc(HALF);
      got[0] = ps2DatIn[ch];
      for (int k = 1; k < 11; k++) begin
        devClk[ch] = 1'b0; waitCyc(HALF);
        got[k] = ps2DatIn[ch];
        devClk[ch] = 1'b1; waitCyc(HALF);
      end
      if (ack) devDat[ch] = 1'b0;
      waitCyc(HALF);
      devClk[ch] = 1'b0; waitCyc(HALF);
      devClk[ch] = 1'b1; waitCyc(HALF);
      devDat[ch] = 1'b1;
      chk("R8 tx bits", got, {1'b1, ~^b, b, 1'b0});
      rd(3'd1, r);
      chk("R8 tx stat", r, {1'b0, expCode(ch), !ack, 1'b0, 1'b1, 1'b1});
      wr(3'd2, 8'h01);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule